// File: doc/BRIEF.md
# Stack Pointer Unit with Bound Traps

This unit owns the stack pointer and an upper-limit register of a 16-bit, byte-addressed data space whose stack grows upward, one 16-bit word at a time. It accepts stack commands on a valid/ready port: push of a data word, pop of a word, a two-word push of a 23-bit return address for a call or an exception, and a two-word return pop. For each word it generates one memory request on a valid/ready memory port. The pointer always holds the address of the next free word. A push writes at the pointer and then advances it by 2. A pop first steps it back by 2 and then reads there. Read data goes straight from the memory to its consumer and does not pass through this unit.

Before a request is issued, its effective address is checked against the limit register and a fixed lower bound of 0x0800. An address above the limit, or below 0x0800, does not reach the memory. It raises a one-cycle trap pulse and sets a sticky trap flag, and the rest of the command is dropped.

Back-pressure rules: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from then until the last word of that command has been handed over or dropped by a trap. A memory request stays asserted, and its address and data stay stable, until `mem_ready` is high. The pointer moves only on a completed handshake.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first command, `sp_o` is 0x0800, `cmd_ready` is 1, `mem_valid` is 0 and `trap_flag` is 0.
- R2: A single push (`cmd_op`=0) makes one write request (`mem_we`=1) at the current pointer with `cmd_word` as data, and the pointer then increases by 2.
- R3: A single pop (`cmd_op`=1) makes one read request (`mem_we`=0) at pointer minus 2, and the pointer then decreases by 2.
- R4: Bit 0 of every value written to the pointer or to the limit is stored as 0.
- R5: A push whose address equals the limit completes without a trap. A push whose address is above the limit traps.
- R6: Any stack address below 0x0800 traps, whether it comes from a pop at 0x0800 or from a push after the pointer was written below 0x0800.
- R7: On a trap, `trap_pulse` is high for exactly one cycle, with no memory request in that cycle. The pointer keeps its value, the remaining words of the command are discarded, and `trap_flag` stays set until a cycle with `trap_clr` high.
- R8: A call push (`cmd_op`=2) writes `cmd_ra[15:0]` at the pointer and then, at pointer+2, a high word made of `cmd_ra[21:16]` in bits 5:0 with every other bit 0. Bit 22 of the return address is therefore cleared.
- R9: An exception push (`cmd_op`=3) writes `cmd_ra[15:0]` first. Its high word carries `cmd_stat` in bits 15:8, 0 in bit 7 and `cmd_ra[22:16]` in bits 6:0.
- R10: A return pop (`cmd_op`=4) makes two read requests, first at pointer minus 2 (the high word) and then at pointer minus 4 (the low word).
- R11: While `mem_ready` is low, a pending request keeps its address, direction and data, and the pointer does not move. `cmd_ready` is low while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | 0 push, 1 pop, 2 call push, 3 exception push, 4 return pop |
| cmd_word | input | 16 | Data word for a single push |
| cmd_ra | input | 23 | Return address for call or exception push |
| cmd_stat | input | 8 | Status bits placed in the exception high word |
| sp_wr_en | input | 1 | Load the pointer |
| sp_wr_data | input | 16 | New pointer value (bit 0 ignored) |
| lim_wr_en | input | 1 | Load the limit |
| lim_wr_data | input | 16 | New limit value (bit 0 ignored) |
| trap_clr | input | 1 | Clear the sticky trap flag |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 write (push), 0 read (pop) |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data, 0 on reads |
| sp_o | output | 16 | Current stack pointer |
| trap_pulse | output | 1 | One-cycle stack-error trap |
| trap_flag | output | 1 | Sticky trap indication |

## Verification
A command taken at a clock edge shows its first memory request, or its trap pulse, in the very next cycle. A two-word command shows its second word in the cycle after the first handshake. `sp_o` and `trap_flag` change at the edge that completes a handshake or records a trap. A behavioural model in the bench, built from queues of pending words, advances at the same edges. The bench compares every output with that model once per cycle, shortly after the falling edge, so each result is judged in exactly the cycle it is due and never one edge early or late.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_EXC  = 3'd3,
    OP_RET  = 3'd4
  } spu_op_e;
endpackage

// File: rtl/spu_frame_fmt.sv
// Forms the word written for each push step.
module spu_frame_fmt
  import spu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int RA_W = 23,
  parameter int ST_W = 8
) (
  input  spu_op_e           op,
  input  logic              hi_sel,
  input  logic [RA_W-1:0]   ra,
  input  logic [ST_W-1:0]   st,
  input  logic [AW-1:0]     word_in,
  output logic [AW-1:0]     word_o
);
  localparam int HI_W  = RA_W - AW;
  localparam int PAD_W = AW - ST_W - HI_W;

  logic [AW-1:0] call_hi, exc_hi;

  // call: top bit of the return address dropped, zero-extended
  assign call_hi = AW'(ra[RA_W-2:AW]);
  // exception: status bits on top, return address high bits below
  assign exc_hi  = {st, {PAD_W{1'b0}}, ra[RA_W-1:AW]};

  always_comb begin
    word_o = '0;
    case (op)
      OP_PUSH: word_o = word_in;
      OP_CALL: word_o = hi_sel ? call_hi : ra[AW-1:0];
      OP_EXC:  word_o = hi_sel ? exc_hi  : ra[AW-1:0];
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/spu_bound_chk.sv
// Compares a stack effective address with the limit and the fixed floor.
module spu_bound_chk #(
  parameter int           AW    = 16,
  parameter logic [15:0]  FLOOR = 16'h0800
) (
  input  logic [AW-1:0] ea,
  input  logic [AW-1:0] lim,
  output logic          over,
  output logic          under
);
  assign over  = ea > lim;
  assign under = ea < AW'(FLOOR);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int           AW      = 16,
  parameter int           RA_W    = 23,
  parameter int           ST_W    = 8,
  parameter logic [15:0]  FLOOR   = 16'h0800,
  parameter logic [15:0]  SP_INIT = 16'h0800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_word,
  input  logic [RA_W-1:0] cmd_ra,
  input  logic [ST_W-1:0] cmd_stat,
  input  logic            sp_wr_en,
  input  logic [AW-1:0]   sp_wr_data,
  input  logic            lim_wr_en,
  input  logic [AW-1:0]   lim_wr_data,
  input  logic            trap_clr,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata,
  output logic [AW-1:0]   sp_o,
  output logic            trap_pulse,
  output logic            trap_flag
);
  localparam logic [AW-1:0] STEP = AW'(2);

  spu_op_e         op_q;
  logic            busy_q, hi_q, flag_q;
  logic [AW-1:0]   sp_q, lim_q, word_q;
  logic [RA_W-1:0] ra_q;
  logic [ST_W-1:0] st_q;

  logic            is_push, two_word, last_word, op_known;
  logic            over, under, bad, fire;
  logic [AW-1:0]   ea, fmt_word;

  assign op_known  = cmd_op <= 3'd4;
  assign is_push   = (op_q == OP_PUSH) || (op_q == OP_CALL) || (op_q == OP_EXC);
  assign two_word  = (op_q == OP_CALL) || (op_q == OP_EXC) || (op_q == OP_RET);
  assign last_word = !two_word || hi_q;
  assign ea        = is_push ? sp_q : sp_q - STEP;

  spu_bound_chk #(.AW(AW), .FLOOR(FLOOR)) i_chk (
    .ea(ea), .lim(lim_q), .over(over), .under(under)
  );

  spu_frame_fmt #(.AW(AW), .RA_W(RA_W), .ST_W(ST_W)) i_fmt (
    .op(op_q), .hi_sel(hi_q), .ra(ra_q), .st(st_q),
    .word_in(word_q), .word_o(fmt_word)
  );

  assign bad        = busy_q && (over || under);
  assign fire       = mem_valid && mem_ready;
  assign cmd_ready  = !busy_q;
  assign mem_valid  = busy_q && !bad;
  assign mem_we     = is_push;
  assign mem_addr   = ea;
  assign mem_wdata  = is_push ? fmt_word : '0;
  assign sp_o       = sp_q;
  assign trap_pulse = bad;
  assign trap_flag  = flag_q;

  // command sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      op_q   <= OP_PUSH;
      word_q <= '0;
      ra_q   <= '0;
      st_q   <= '0;
    end else if (cmd_valid && cmd_ready && op_known) begin
      busy_q <= 1'b1;
      hi_q   <= 1'b0;
      op_q   <= spu_op_e'(cmd_op);
      word_q <= cmd_word;
      ra_q   <= cmd_ra;
      st_q   <= cmd_stat;
    end else if (bad) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
    end else if (fire) begin
      if (last_word) begin
        busy_q <= 1'b0;
        hi_q   <= 1'b0;
      end else begin
        hi_q <= 1'b1;
      end
    end
  end

  // pointer and sticky flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= SP_INIT;
      flag_q <= 1'b0;
    end else begin
      if (sp_wr_en)  sp_q <= {sp_wr_data[AW-1:1], 1'b0};
      else if (fire) sp_q <= is_push ? sp_q + STEP : sp_q - STEP;
      if (bad)           flag_q <= 1'b1;
      else if (trap_clr) flag_q <= 1'b0;
    end
  end

  // limit register carries no reset value
  always_ff @(posedge clk) begin
    if (lim_wr_en) lim_q <= {lim_wr_data[AW-1:1], 1'b0};
  end

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mem_we && !sp_wr_en |=> sp_q == $past(sp_q) + STEP);
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !mem_we && !sp_wr_en |=> sp_q == $past(sp_q) - STEP);
  assert_aligned_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !mem_addr[0]);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |=> !trap_pulse && trap_flag);
  assert_trap_sp_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse && !sp_wr_en |=> $stable(sp_q));
  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !sp_wr_en && !lim_wr_en
    |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we) && $stable(sp_q));
  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cmd_ready);
endmodule

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/1ps
module test_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_word = '0;
  logic [22:0] cmd_ra = '0;
  logic [7:0]  cmd_stat = '0;
  logic        sp_wr_en = 1'b0, lim_wr_en = 1'b0, trap_clr = 1'b0;
  logic [15:0] sp_wr_data = '0, lim_wr_data = '0;
  logic        mem_valid, mem_ready = 1'b1, mem_we;
  logic [15:0] mem_addr, mem_wdata, sp_o;
  logic        trap_pulse, trap_flag;

  always #2.5 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_word(cmd_word), .cmd_ra(cmd_ra), .cmd_stat(cmd_stat),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .lim_wr_en(lim_wr_en),
    .lim_wr_data(lim_wr_data), .trap_clr(trap_clr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sp_o(sp_o), .trap_pulse(trap_pulse),
    .trap_flag(trap_flag)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { bit push; int data; } ent_t;
  ent_t q[$];
  int m_sp = 'h800, m_lim = 0;
  bit m_flag = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs with the model, then advance the model
  task automatic tick(string req);
    bit bad, fire, was_empty;
    int ea, nsp;
    ent_t e;
    #1;
    was_empty = (q.size() == 0);
    bad = 0; fire = 0; ea = 0;
    if (!was_empty) begin
      e = q[0];
      ea = e.push ? m_sp : ((m_sp - 2) & 'hFFFF);
      bad = (ea > m_lim) || (ea < 'h800);
      fire = !bad && mem_ready;
    end
    chk(req, "cmd_ready", cmd_ready, was_empty);
    chk(req, "mem_valid", mem_valid, !was_empty && !bad);
    chk(req, "trap_pulse", trap_pulse, bad);
    chk(req, "trap_flag", trap_flag, m_flag);
    chk(req, "sp_o", sp_o, m_sp);
    if (!was_empty && !bad) begin
      chk(req, "mem_addr", mem_addr, ea);
      chk(req, "mem_we", mem_we, e.push);
      if (e.push) chk(req, "mem_wdata", mem_wdata, e.data);
    end
    nsp = m_sp;
    if (fire) nsp = e.push ? m_sp + 2 : m_sp - 2;
    if (sp_wr_en) nsp = sp_wr_data & 'hFFFE;
    if (bad) q.delete();
    else if (fire) void'(q.pop_front());
    if (bad) m_flag = 1; else if (trap_clr) m_flag = 0;
    if (lim_wr_en) m_lim = lim_wr_data & 'hFFFE;
    if (cmd_valid && was_empty) begin
      case (cmd_op)
        3'd0: q.push_back('{1, cmd_word});
        3'd1: q.push_back('{0, 0});
        3'd2: begin
          q.push_back('{1, cmd_ra[15:0]});
          q.push_back('{1, {10'b0, cmd_ra[21:16]}});
        end
        3'd3: begin
          q.push_back('{1, cmd_ra[15:0]});
          q.push_back('{1, {cmd_stat, 1'b0, cmd_ra[22:16]}});
        end
        3'd4: begin q.push_back('{0, 0}); q.push_back('{0, 0}); end
        default: ;
      endcase
    end
    m_sp = nsp & 'hFFFF;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; sp_wr_en = 0; lim_wr_en = 0; trap_clr = 0;
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic cmd(bit [2:0] op, bit [15:0] w, bit [22:0] ra, bit [7:0] st, string req);
    cmd_valid = 1; cmd_op = op; cmd_word = w; cmd_ra = ra; cmd_stat = st;
    tick(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: values held in reset
    chk("R1", "sp_o", sp_o, 'h800);
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "mem_valid", mem_valid, 0);
    chk("R1", "trap_flag", trap_flag, 0);
    rst_n = 1;
    idle(2, "R1");

    // R4: odd limit and pointer writes lose bit 0
    lim_wr_en = 1; lim_wr_data = 16'h0805; tick("R4");
    sp_wr_en = 1; sp_wr_data = 16'h0801; tick("R4");
    idle(1, "R4");

    // R2 pushes, R5 push at limit then beyond
    cmd(3'd0, 16'h1111, 0, 0, "R2"); idle(2, "R2");
    cmd(3'd0, 16'h2222, 0, 0, "R2"); idle(2, "R2");
    cmd(3'd0, 16'h3333, 0, 0, "R5"); idle(2, "R5");
    cmd(3'd0, 16'h4444, 0, 0, "R5"); idle(3, "R7");
    trap_clr = 1; tick("R7");
    idle(1, "R7");

    // R3 pops, then underflow at the floor (R6)
    for (int i = 0; i < 3; i++) begin cmd(3'd1, 0, 0, 0, "R3"); idle(2, "R3"); end
    cmd(3'd1, 0, 0, 0, "R6"); idle(2, "R6");
    trap_clr = 1; tick("R7");

    // R11 back-pressure
    lim_wr_en = 1; lim_wr_data = 16'h1000; tick("R11");
    mem_ready = 0;
    cmd(3'd0, 16'hBEEF, 0, 0, "R11"); idle(3, "R11");
    mem_ready = 1; idle(2, "R11");
    mem_ready = 0;
    cmd(3'd2, 0, 23'h5A_1234, 0, "R11"); idle(2, "R11");
    mem_ready = 1; idle(1, "R11");
    mem_ready = 0; idle(2, "R11");
    mem_ready = 1; idle(2, "R11");

    // R8 call with bit 22 set, R9 exception, R10 returns
    cmd(3'd2, 0, 23'h7A_BCDE, 0, "R8"); idle(3, "R8");
    cmd(3'd3, 0, 23'h6B_0F0F, 8'hC3, "R9"); idle(3, "R9");
    cmd(3'd3, 0, 23'h1F_FFFF, 8'h5A, "R9"); idle(3, "R9");
    cmd(3'd4, 0, 0, 0, "R10"); idle(3, "R10");
    cmd(3'd4, 0, 0, 0, "R10"); idle(3, "R10");

    // R7 trap on the second word of a call
    lim_wr_en = 1; lim_wr_data = sp_o; tick("R7");
    cmd(3'd2, 0, 23'h00_ABCD, 0, "R7"); idle(3, "R7");
    trap_clr = 1; tick("R7");

    // R6 push after pointer written below the floor
    lim_wr_en = 1; lim_wr_data = 16'hFFFE; tick("R6");
    sp_wr_en = 1; sp_wr_data = 16'h07F0; tick("R6");
    cmd(3'd0, 16'h5555, 0, 0, "R6"); idle(2, "R6");
    sp_wr_en = 1; sp_wr_data = 16'h0900; tick("R6");
    cmd(3'd0, 16'h6666, 0, 0, "R2"); idle(2, "R2");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule